// File: doc/BRIEF.md
# Scaler Request Admission Checker

This block judges one scaling request at a time from one of several scaler users, such as display planes or the pipe itself. It decides whether the request may hold a scaler and keeps a bitmask of the users that currently hold one. Each request carries the user index, the source and destination width and height, the pipe source size, a semiplanar-YUV flag, an interlaced-output flag, a force-release flag, a need-scaler hint and a two-bit generation select. The size limits follow the generation select.

A request is presented with a one-cycle strobe. One clock later the block returns a response: accept or reject, a reason code, and the updated user mask. A request that no longer needs scaling, or that asks to be detached, only releases the user's claim. This release is staged in the mask, and it takes priority over every rejection. Choosing which physical scaler serves a user, and programming that scaler, are left to other logic.

Top module: `scl_adm`

## Requirements
- R1: When `req_valid` is high at a rising clock edge, `resp_valid` is high for exactly the following cycle, together with `resp_accept`, `resp_code` and the updated `user_mask`.
- R2: A synchronous `rst` clears `user_mask` to zero and drives `resp_valid` low.
- R3: If `force_release` is set, or scaling is not needed, the request is accepted with code 0 and the user's mask bit is cleared. This check takes priority over every rejection, including interlace, size and pipe checks.
- R4: Scaling is needed when `need_scale` is set, or when the source width differs from the destination width, or when the source height differs from the destination height.
- R5: A request that needs scaling while `mode_interlaced` is set is rejected with code 1.
- R6: A request that needs scaling, with `fmt_semiplanar` set and a source width or height below 16, is rejected with code 2. This check ranks above the size range check.
- R7: A source or destination dimension below 8 is rejected with code 3, for every generation.
- R8: The maximum sizes (width x height) depend on `gen_sel`, and any dimension above its maximum is rejected with code 3:
  - `gen_sel` 0: source 4096x4096, destination 4096x4096.
  - `gen_sel` 1: source 5120x4096, destination 5120x4096.
  - `gen_sel` 2: source 5120x8192, destination 8192x8192.
  - `gen_sel` 3: source 4096x8192, destination 8192x8192.
- R9: A pipe source width or height that exceeds the generation's maximum source size is rejected with code 4. This is the lowest-priority check.
- R10: A request that needs scaling and passes every check is accepted with code 0. It sets the user's bit in `user_mask` and leaves the other bits unchanged. `resp_accept` is high exactly when `resp_code` is 0.
- R11: A rejected request leaves `user_mask` unchanged.
- R12: With no strobe, `resp_valid` stays low and `user_mask` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request strobe |
| req_user | input | USER_W (3) | Requesting user index |
| req_src_w | input | DIM_W (14) | Source width |
| req_src_h | input | DIM_W (14) | Source height |
| req_dst_w | input | DIM_W (14) | Destination width |
| req_dst_h | input | DIM_W (14) | Destination height |
| pipe_src_w | input | DIM_W (14) | Pipe source width |
| pipe_src_h | input | DIM_W (14) | Pipe source height |
| fmt_semiplanar | input | 1 | Source is semiplanar YUV |
| mode_interlaced | input | 1 | Output mode is interlaced |
| force_release | input | 1 | Detach the user regardless of sizes |
| need_scale | input | 1 | Caller hint that a scaler is required |
| gen_sel | input | 2 | Generation select for size limits |
| resp_valid | output | 1 | Response valid, one cycle after the strobe |
| resp_accept | output | 1 | Request accepted |
| resp_code | output | 3 | 0 ok, 1 interlaced, 2 YUV too small, 3 size out of range, 4 pipe source too large |
| user_mask | output | NUM_USERS (8) | Users currently holding a scaler |

## Verification
The bound checker watches several rules on every cycle:
- the one-cycle response timing and the silence when no request is strobed;
- agreement between the accept flag and a zero code;
- an unchanged mask after a rejection, and no change to any bit other than the requester's;
- a cleared bit after a forced release;
- the interlace rejection code.

The per-generation limits at and just past each boundary, and the ordering among the YUV, range and pipe checks, can only be shown by the bench's directed scenarios. The same holds for the release outranking bad sizes and interlace, and for a reset that clears a populated mask.

// File: rtl/scl_adm_pkg.sv
package scl_adm_pkg;

   typedef enum logic [2:0] {
      ADM_OK        = 3'd0,
      ADM_INTERLACE = 3'd1,
      ADM_YUV_SMALL = 3'd2,
      ADM_RANGE     = 3'd3,
      ADM_PIPE_SRC  = 3'd4
   } adm_code_e;

   typedef enum logic [1:0] {
      GEN_A = 2'd0,
      GEN_B = 2'd1,
      GEN_C = 2'd2,
      GEN_D = 2'd3
   } adm_gen_e;

endpackage

// File: rtl/scl_adm_limits.sv
module scl_adm_limits #(
   parameter int unsigned DIM_W     = 14,
   parameter int unsigned A_SRC_W   = 4096,
   parameter int unsigned A_SRC_H   = 4096,
   parameter int unsigned A_DST_W   = 4096,
   parameter int unsigned A_DST_H   = 4096,
   parameter int unsigned B_SRC_W   = 5120,
   parameter int unsigned B_SRC_H   = 4096,
   parameter int unsigned B_DST_W   = 5120,
   parameter int unsigned B_DST_H   = 4096,
   parameter int unsigned C_SRC_W   = 5120,
   parameter int unsigned C_SRC_H   = 8192,
   parameter int unsigned C_DST_W   = 8192,
   parameter int unsigned C_DST_H   = 8192,
   parameter int unsigned D_SRC_W   = 4096,
   parameter int unsigned D_SRC_H   = 8192,
   parameter int unsigned D_DST_W   = 8192,
   parameter int unsigned D_DST_H   = 8192
) (
   input  logic [1:0]       gen_sel,
   output logic [DIM_W-1:0] max_src_w,
   output logic [DIM_W-1:0] max_src_h,
   output logic [DIM_W-1:0] max_dst_w,
   output logic [DIM_W-1:0] max_dst_h
);
   import scl_adm_pkg::*;

   localparam int unsigned DIM_MAX = (1 << DIM_W) - 1;

   if (A_SRC_W > DIM_MAX || A_SRC_H > DIM_MAX || A_DST_W > DIM_MAX || A_DST_H > DIM_MAX ||
       B_SRC_W > DIM_MAX || B_SRC_H > DIM_MAX || B_DST_W > DIM_MAX || B_DST_H > DIM_MAX ||
       C_SRC_W > DIM_MAX || C_SRC_H > DIM_MAX || C_DST_W > DIM_MAX || C_DST_H > DIM_MAX ||
       D_SRC_W > DIM_MAX || D_SRC_H > DIM_MAX || D_DST_W > DIM_MAX || D_DST_H > DIM_MAX)
   begin : g_bad_limit
      $error("scl_adm_limits: a limit does not fit in DIM_W bits");
   end

   always_comb begin
      unique case (adm_gen_e'(gen_sel))
         GEN_A: begin
            max_src_w = DIM_W'(A_SRC_W);
            max_src_h = DIM_W'(A_SRC_H);
            max_dst_w = DIM_W'(A_DST_W);
            max_dst_h = DIM_W'(A_DST_H);
         end
         GEN_B: begin
            max_src_w = DIM_W'(B_SRC_W);
            max_src_h = DIM_W'(B_SRC_H);
            max_dst_w = DIM_W'(B_DST_W);
            max_dst_h = DIM_W'(B_DST_H);
         end
         GEN_C: begin
            max_src_w = DIM_W'(C_SRC_W);
            max_src_h = DIM_W'(C_SRC_H);
            max_dst_w = DIM_W'(C_DST_W);
            max_dst_h = DIM_W'(C_DST_H);
         end
         default: begin
            max_src_w = DIM_W'(D_SRC_W);
            max_src_h = DIM_W'(D_SRC_H);
            max_dst_w = DIM_W'(D_DST_W);
            max_dst_h = DIM_W'(D_DST_H);
         end
      endcase
   end

endmodule

// File: rtl/scl_adm_decide.sv
module scl_adm_decide #(
   parameter int unsigned DIM_W   = 14,
   parameter int unsigned MIN_DIM = 8,
   parameter int unsigned YUV_MIN = 16
) (
   input  logic [DIM_W-1:0] src_w,
   input  logic [DIM_W-1:0] src_h,
   input  logic [DIM_W-1:0] dst_w,
   input  logic [DIM_W-1:0] dst_h,
   input  logic [DIM_W-1:0] pipe_w,
   input  logic [DIM_W-1:0] pipe_h,
   input  logic [DIM_W-1:0] max_src_w,
   input  logic [DIM_W-1:0] max_src_h,
   input  logic [DIM_W-1:0] max_dst_w,
   input  logic [DIM_W-1:0] max_dst_h,
   input  logic             semiplanar,
   input  logic             interlaced,
   input  logic             release_req,
   input  logic             need_hint,
   output logic             do_release,
   output logic             do_grant,
   output logic [2:0]       code
);
   import scl_adm_pkg::*;

   localparam logic [DIM_W-1:0] MIN_V = DIM_W'(MIN_DIM);
   localparam logic [DIM_W-1:0] YUV_V = DIM_W'(YUV_MIN);

   logic scale_req;
   logic yuv_small;
   logic under_min;
   logic over_max;
   logic pipe_big;

   // all comparators run in parallel; only the selection below is ordered
   assign scale_req = need_hint || (src_w != dst_w) || (src_h != dst_h);
   assign yuv_small = semiplanar && ((src_w < YUV_V) || (src_h < YUV_V));
   assign under_min = (src_w < MIN_V) || (src_h < MIN_V) ||
                      (dst_w < MIN_V) || (dst_h < MIN_V);
   assign over_max  = (src_w > max_src_w) || (src_h > max_src_h) ||
                      (dst_w > max_dst_w) || (dst_h > max_dst_h);
   assign pipe_big  = (pipe_w > max_src_w) || (pipe_h > max_src_h);

   always_comb begin
      do_release = 1'b0;
      do_grant   = 1'b0;
      code       = ADM_OK;
      if (release_req || !scale_req) begin
         do_release = 1'b1;
      end else if (interlaced) begin
         code = ADM_INTERLACE;
      end else if (yuv_small) begin
         code = ADM_YUV_SMALL;
      end else if (under_min || over_max) begin
         code = ADM_RANGE;
      end else if (pipe_big) begin
         code = ADM_PIPE_SRC;
      end else begin
         do_grant = 1'b1;
      end
   end

endmodule

// File: rtl/scl_adm_mask.sv
module scl_adm_mask #(
   parameter int unsigned NUM_USERS = 8,
   localparam int unsigned USER_W   = $clog2(NUM_USERS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 set_en,
   input  logic                 clr_en,
   input  logic [USER_W-1:0]    user,
   output logic [NUM_USERS-1:0] mask
);

   for (genvar i = 0; i < NUM_USERS; i++) begin : g_bit
      logic hold_q;
      logic hit;
      assign hit = (user == USER_W'(i));
      always_ff @(posedge clk) begin
         if (rst) begin
            hold_q <= 1'b0;
         end else if (hit && set_en) begin
            hold_q <= 1'b1;
         end else if (hit && clr_en) begin
            hold_q <= 1'b0;
         end
      end
      assign mask[i] = hold_q;
   end

endmodule

// File: rtl/scl_adm.sv
module scl_adm #(
   parameter int unsigned NUM_USERS = 8,
   parameter int unsigned DIM_W     = 14,
   parameter int unsigned MIN_DIM   = 8,
   parameter int unsigned YUV_MIN   = 16,
   localparam int unsigned USER_W   = $clog2(NUM_USERS)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 req_valid,
   input  logic [USER_W-1:0]    req_user,
   input  logic [DIM_W-1:0]     req_src_w,
   input  logic [DIM_W-1:0]     req_src_h,
   input  logic [DIM_W-1:0]     req_dst_w,
   input  logic [DIM_W-1:0]     req_dst_h,
   input  logic [DIM_W-1:0]     pipe_src_w,
   input  logic [DIM_W-1:0]     pipe_src_h,
   input  logic                 fmt_semiplanar,
   input  logic                 mode_interlaced,
   input  logic                 force_release,
   input  logic                 need_scale,
   input  logic [1:0]           gen_sel,
   output logic                 resp_valid,
   output logic                 resp_accept,
   output logic [2:0]           resp_code,
   output logic [NUM_USERS-1:0] user_mask
);

   if (NUM_USERS < 2 || NUM_USERS > 8 || (1 << USER_W) != NUM_USERS) begin : g_bad_users
      $error("scl_adm: NUM_USERS must be 2, 4 or 8");
   end
   if (DIM_W < 14 || DIM_W > 16) begin : g_bad_dim
      $error("scl_adm: DIM_W must hold 8192 and stay within 16 bits");
   end
   if (MIN_DIM < 1 || YUV_MIN < MIN_DIM) begin : g_bad_min
      $error("scl_adm: minimum sizes inconsistent");
   end

   logic [DIM_W-1:0] lim_src_w, lim_src_h, lim_dst_w, lim_dst_h;
   logic             dec_release, dec_grant;
   logic [2:0]       dec_code;

   scl_adm_limits #(.DIM_W(DIM_W)) u_limits (
      .gen_sel   (gen_sel),
      .max_src_w (lim_src_w),
      .max_src_h (lim_src_h),
      .max_dst_w (lim_dst_w),
      .max_dst_h (lim_dst_h)
   );

   scl_adm_decide #(
      .DIM_W   (DIM_W),
      .MIN_DIM (MIN_DIM),
      .YUV_MIN (YUV_MIN)
   ) u_decide (
      .src_w       (req_src_w),
      .src_h       (req_src_h),
      .dst_w       (req_dst_w),
      .dst_h       (req_dst_h),
      .pipe_w      (pipe_src_w),
      .pipe_h      (pipe_src_h),
      .max_src_w   (lim_src_w),
      .max_src_h   (lim_src_h),
      .max_dst_w   (lim_dst_w),
      .max_dst_h   (lim_dst_h),
      .semiplanar  (fmt_semiplanar),
      .interlaced  (mode_interlaced),
      .release_req (force_release),
      .need_hint   (need_scale),
      .do_release  (dec_release),
      .do_grant    (dec_grant),
      .code        (dec_code)
   );

   scl_adm_mask #(.NUM_USERS(NUM_USERS)) u_mask (
      .clk    (clk),
      .rst    (rst),
      .set_en (req_valid && dec_grant),
      .clr_en (req_valid && dec_release),
      .user   (req_user),
      .mask   (user_mask)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         resp_valid  <= 1'b0;
         resp_accept <= 1'b0;
         resp_code   <= 3'd0;
      end else begin
         resp_valid <= req_valid;
         if (req_valid) begin
            resp_accept <= dec_grant || dec_release;
            resp_code   <= dec_code;
         end
      end
   end

endmodule

// File: rtl/scl_adm_chk.sv
module scl_adm_chk #(
   parameter int unsigned NUM_USERS = 8,
   parameter int unsigned DIM_W     = 14,
   localparam int unsigned USER_W   = $clog2(NUM_USERS)
) (
   input logic                 clk,
   input logic                 rst,
   input logic                 req_valid,
   input logic [USER_W-1:0]    req_user,
   input logic [DIM_W-1:0]     req_src_w,
   input logic [DIM_W-1:0]     req_dst_w,
   input logic                 mode_interlaced,
   input logic                 force_release,
   input logic                 resp_valid,
   input logic                 resp_accept,
   input logic [2:0]           resp_code,
   input logic [NUM_USERS-1:0] user_mask
);
   localparam logic [NUM_USERS-1:0] ONE = NUM_USERS'(1);

   p_resp_follows_req_r1: assert property (@(posedge clk) disable iff (rst)
      req_valid |=> resp_valid);

   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (rst)
      !req_valid |=> (!resp_valid && $stable(user_mask)));

   p_release_clears_r3: assert property (@(posedge clk) disable iff (rst)
      (req_valid && force_release) |=>
         (resp_accept && ((user_mask & (ONE << $past(req_user))) == '0)));

   p_interlace_reject_r5: assert property (@(posedge clk) disable iff (rst)
      (req_valid && !force_release && mode_interlaced && (req_src_w != req_dst_w)) |=>
         (!resp_accept && resp_code == 3'd1));

   p_accept_means_ok_r10: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> (resp_accept == (resp_code == 3'd0)));

   p_other_bits_kept_r10: assert property (@(posedge clk) disable iff (rst)
      resp_valid |-> (((user_mask ^ $past(user_mask)) & ~(ONE << $past(req_user))) == '0));

   p_reject_keeps_mask_r11: assert property (@(posedge clk) disable iff (rst)
      (resp_valid && !resp_accept) |-> (user_mask == $past(user_mask)));

endmodule

bind scl_adm scl_adm_chk #(.NUM_USERS(NUM_USERS), .DIM_W(DIM_W)) u_chk (
   .clk             (clk),
   .rst             (rst),
   .req_valid       (req_valid),
   .req_user        (req_user),
   .req_src_w       (req_src_w),
   .req_dst_w       (req_dst_w),
   .mode_interlaced (mode_interlaced),
   .force_release   (force_release),
   .resp_valid      (resp_valid),
   .resp_accept     (resp_accept),
   .resp_code       (resp_code),
   .user_mask       (user_mask)
);

// File: tb/scl_adm_bench.sv
module scl_adm_bench;
   localparam int NU = 8;
   localparam int DW = 14;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          req_valid = 1'b0;
   logic [2:0]    req_user = '0;
   logic [DW-1:0] req_src_w = '0, req_src_h = '0, req_dst_w = '0, req_dst_h = '0;
   logic [DW-1:0] pipe_src_w = '0, pipe_src_h = '0;
   logic          fmt_semiplanar = 1'b0, mode_interlaced = 1'b0;
   logic          force_release = 1'b0, need_scale = 1'b0;
   logic [1:0]    gen_sel = '0;
   logic          resp_valid, resp_accept;
   logic [2:0]    resp_code;
   logic [NU-1:0] user_mask;

   int tests = 0;
   int fails = 0;
   logic [NU-1:0] exp_mask = '0;
   bit done = 0;

   always #10 clk = ~clk;

   scl_adm u_scl_adm (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_user(req_user),
      .req_src_w(req_src_w), .req_src_h(req_src_h),
      .req_dst_w(req_dst_w), .req_dst_h(req_dst_h),
      .pipe_src_w(pipe_src_w), .pipe_src_h(pipe_src_h),
      .fmt_semiplanar(fmt_semiplanar), .mode_interlaced(mode_interlaced),
      .force_release(force_release), .need_scale(need_scale), .gen_sel(gen_sel),
      .resp_valid(resp_valid), .resp_accept(resp_accept),
      .resp_code(resp_code), .user_mask(user_mask)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   // kind: 0 grant, 1 release, 2 reject with ecode
   task automatic do_req(input int usr, input int sw, input int sh, input int dw, input int dh,
                         input int pw, input int ph, input bit semi, input bit intl,
                         input bit det, input bit need, input int gen,
                         input int kind, input int ecode, input string tag);
      @(negedge clk);
      req_user = 3'(usr);
      req_src_w = DW'(sw); req_src_h = DW'(sh);
      req_dst_w = DW'(dw); req_dst_h = DW'(dh);
      pipe_src_w = DW'(pw); pipe_src_h = DW'(ph);
      fmt_semiplanar = semi; mode_interlaced = intl;
      force_release = det; need_scale = need; gen_sel = 2'(gen);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      if (kind == 0) exp_mask[usr] = 1'b1;
      if (kind == 1) exp_mask[usr] = 1'b0;
      chk(resp_valid == 1'b1, {tag, " R1 resp_valid"}, int'(resp_valid), 1);
      chk(resp_accept == (kind != 2), {tag, " accept"}, int'(resp_accept), int'(kind != 2));
      chk(int'(resp_code) == ((kind == 2) ? ecode : 0), {tag, " code"},
          int'(resp_code), (kind == 2) ? ecode : 0);
      chk(user_mask == exp_mask, {tag, " mask"}, int'(user_mask), int'(exp_mask));
   endtask

   task automatic t_reset(input string tag);
      @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      exp_mask = '0;
      chk(user_mask == '0, {tag, " R2 mask"}, int'(user_mask), 0);
      chk(resp_valid == 1'b0, {tag, " R2 resp_valid"}, int'(resp_valid), 0);
      rst = 1'b0;
   endtask

   task automatic t_idle();
      @(negedge clk);
      req_user = 3'd7; req_src_w = DW'(3); req_dst_w = DW'(9000);
      force_release = 1'b1; need_scale = 1'b1;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         chk(resp_valid == 1'b0, "R12 idle resp_valid", int'(resp_valid), 0);
         chk(user_mask == exp_mask, "R12 idle mask", int'(user_mask), int'(exp_mask));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++;
         tests++;
         $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      t_reset("R2 initial");
      // grants and releases (R10, R4, R3)
      do_req(2, 1920,1080, 3840,2160, 1920,1080, 0,0,0,0, 0, 0,0, "R10 grant u2");
      do_req(5, 100,100, 100,100, 100,100, 0,0,0,1, 0, 0,0, "R4 hint grant u5");
      do_req(0, 640,480, 640,481, 640,480, 0,0,0,0, 0, 0,0, "R4 height differs u0");
      do_req(5, 100,100, 100,100, 100,100, 0,0,0,0, 0, 1,0, "R3 no scale release u5");
      // interlace (R5) and release priority (R3)
      do_req(1, 800,600, 1600,1200, 800,600, 0,1,0,0, 0, 2,1, "R5 interlace reject");
      do_req(3, 800,600, 800,600, 800,600, 0,1,0,0, 0, 1,0, "R3 interlace no scale");
      do_req(0, 3,5, 9000,9000, 9000,9000, 1,1,1,1, 0, 1,0, "R3 forced release wins");
      // semiplanar minimum (R6)
      do_req(4, 15,100, 30,200, 100,100, 1,0,0,0, 2, 2,2, "R6 yuv narrow");
      do_req(4, 100,15, 200,30, 100,100, 1,0,0,0, 2, 2,2, "R6 yuv short");
      do_req(4, 8,8, 9000,16, 100,100, 1,0,0,0, 0, 2,2, "R6 yuv beats range");
      do_req(4, 16,16, 32,32, 16,16, 1,0,0,0, 0, 0,0, "R6 yuv at 16 grant");
      // minimum size (R7)
      do_req(6, 7,100, 14,200, 100,100, 0,0,0,0, 3, 2,3, "R7 src_w 7");
      do_req(6, 100,100, 200,7, 100,100, 0,0,0,0, 1, 2,3, "R7 dst_h 7");
      do_req(6, 8,8, 16,8, 8,8, 0,0,0,0, 2, 0,0, "R7 size 8 grant");
      // per-generation maxima (R8)
      do_req(7, 4097,100, 200,200, 100,100, 0,0,0,0, 0, 2,3, "R8 genA src_w 4097");
      do_req(7, 100,100, 100,4097, 100,100, 0,0,0,0, 0, 2,3, "R8 genA dst_h 4097");
      do_req(7, 5120,4096, 5120,4096, 5120,4096, 0,0,0,1, 1, 0,0, "R8 genB max grant");
      do_req(7, 5121,100, 200,200, 100,100, 0,0,0,0, 1, 2,3, "R8 genB src_w 5121");
      do_req(7, 100,4097, 200,200, 100,100, 0,0,0,0, 1, 2,3, "R8 genB src_h 4097");
      do_req(1, 5120,8192, 8192,8192, 5120,8192, 0,0,0,0, 2, 0,0, "R8 genC max grant");
      do_req(1, 100,100, 8193,200, 100,100, 0,0,0,0, 2, 2,3, "R8 genC dst_w 8193");
      do_req(1, 5121,100, 200,200, 100,100, 0,0,0,0, 2, 2,3, "R8 genC src_w 5121");
      do_req(3, 5120,100, 200,200, 100,100, 0,0,0,0, 3, 2,3, "R8 genD src_w 5120");
      do_req(3, 4096,8192, 8192,8192, 4096,8192, 0,0,0,0, 3, 0,0, "R8 genD max grant");
      // pipe source (R9)
      do_req(0, 100,100, 200,200, 4097,100, 0,0,0,0, 0, 2,4, "R9 genA pipe_w");
      do_req(0, 100,100, 200,200, 5000,100, 0,0,0,0, 3, 2,4, "R9 genD pipe_w");
      do_req(0, 100,100, 200,200, 100,8193, 0,0,0,0, 2, 2,4, "R9 genC pipe_h");
      do_req(0, 4097,100, 200,200, 5000,100, 0,0,0,0, 0, 2,3, "R9 range outranks pipe");
      do_req(1, 500,500, 500,500, 9000,9000, 0,0,0,0, 0, 1,0, "R3 release ignores pipe");
      // quiet cycles (R12), then reset of a populated mask (R2)
      t_idle();
      t_reset("R2 mid-run");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

endmodule